// File: doc/BRIEF.md
# Card Reset and Reference Clock Enable Sequencer

This block drives the two sideband controls of a hot-plug card slot: an active-low reset to the card and an enable for the reference-clock PLL. It watches four kinds of input: one power-good flag per switched rail, a card-present flag, a chip enable, and a reset request from the host. The analog comparators, rail switches and PLL sit outside the block and reach it only as digital levels.

The clock enable follows the power and presence state directly. The card reset is released only after every condition has held for a programmed delay, counted in clock cycles. Any lost condition pulls both outputs back down within a few cycles. All inputs pass through a synchroniser first, so the block can take levels from other clock domains or from analog circuits.

Top module: `card_slot_seq`

## Requirements
- R1: `refclk_en` is 1 exactly when `chip_en`, `card_in` and every bit of `rail_good` were all 1 at the clock edge SYNC_STAGES+1 cycles earlier (3 cycles with the defaults). Otherwise it is 0.
- R2: `host_rst_n` has no effect on `refclk_en`. With power and presence good, driving `host_rst_n` low leaves `refclk_en` at 1.
- R3: `card_rst_n` can be 1 only when `refclk_en` is 1 and `host_rst_n` was also 1, SYNC_STAGES+1 cycles earlier.
- R4: The release delay is D = TICKS_PER_US*DELAY_US cycles. DELAY_US must lie in 4000..20000, and the default is 10000. Once all release conditions become 1 and stay 1, `card_rst_n` is still 0 after SYNC_STAGES+D-1 edges and is 1 after SYNC_STAGES+D edges.
- R5: Losing any release condition drives `card_rst_n` to 0 after SYNC_STAGES+1 edges. That is 12 ns at 250 MHz, well inside a 500 ns bound.
- R6: A loss of any condition during the delay clears the count. After the conditions return, the full delay of R4 is counted again.
- R7: `chip_en` = 0 forces both outputs to 0 after SYNC_STAGES+1 edges and holds them there.
- R8: A synchronous active-high `rst` clears both outputs on the next edge, together with the synchroniser and the delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; TICKS_PER_US cycles per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable; 1 = operate |
| card_in | input | 1 | Card presence; 1 = card inserted |
| host_rst_n | input | 1 | Host reset request; 0 = hold card in reset |
| rail_good | input | NUM_RAILS | Power-good flag per rail; 1 = above threshold |
| card_rst_n | output | 1 | Active-low card reset |
| refclk_en | output | 1 | Reference-clock PLL enable |

## Verification
The properties assume the inputs are plain levels that the synchroniser samples on each edge. They relate each output to input values exactly SYNC_STAGES+1 cycles back, with no allowance for inputs that move within a sampling window. The bench therefore changes inputs only just after a rising edge and holds each pattern for whole cycles. The release-delay property assumes the conditions are counted from their input-side arrival. The stimulus keeps the delay short by setting one tick per microsecond at the 4000 us minimum, so each wait is a bounded, known number of cycles.

// File: rtl/card_slot_seq_pkg.sv
package card_slot_seq_pkg;

  // Legal window for the release delay, in microseconds.
  localparam int unsigned MIN_DELAY_US = 4000;
  localparam int unsigned MAX_DELAY_US = 20000;

  // Qualified conditions after synchronisation.
  typedef struct packed {
    logic clk_ok;   // enable, presence and every rail good
    logic rel_ok;   // clk_ok plus host reset released
  } slot_qual_t;

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/slot_qual.sv
module slot_qual
  import card_slot_seq_pkg::*;
#(
  parameter int NUM_RAILS = 3
) (
  input  logic                 en_s,
  input  logic                 card_s,
  input  logic                 host_s,
  input  logic [NUM_RAILS-1:0] rails_s,
  output slot_qual_t           qual
);

  always_comb begin
    qual.clk_ok = en_s && card_s && (&rails_s);
    qual.rel_ok = qual.clk_ok && host_s;
  end

endmodule

// File: rtl/slot_release_timer.sv
module slot_release_timer #(
  parameter int unsigned DELAY_CYC = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic released
);

  localparam int unsigned CW   = $clog2(DELAY_CYC + 1);
  localparam int unsigned LAST = DELAY_CYC - 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      cnt      <= '0;
      released <= 1'b0;
    end else if (cnt == CW'(LAST)) begin
      released <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/card_slot_seq.sv
module card_slot_seq
  import card_slot_seq_pkg::*;
#(
  parameter int NUM_RAILS          = 3,
  parameter int SYNC_STAGES        = 2,
  parameter int unsigned TICKS_PER_US = 250,
  parameter int unsigned DELAY_US  = 10000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 chip_en,
  input  logic                 card_in,
  input  logic                 host_rst_n,
  input  logic [NUM_RAILS-1:0] rail_good,
  output logic                 card_rst_n,
  output logic                 refclk_en
);

  localparam int unsigned DELAY_CYC = TICKS_PER_US * DELAY_US;
  localparam int          SW        = NUM_RAILS + 3;

  if (DELAY_US < MIN_DELAY_US || DELAY_US > MAX_DELAY_US) begin : g_bad_delay
    $error("card_slot_seq: DELAY_US outside the 4000..20000 window");
  end

  logic [SW-1:0]        raw_bus, sync_bus;
  logic [NUM_RAILS-1:0] rails_s;
  slot_qual_t           qual;
  logic                 refclk_q;
  logic                 released;

  assign raw_bus = {chip_en, card_in, host_rst_n, rail_good};

  slot_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  assign rails_s = sync_bus[NUM_RAILS-1:0];

  slot_qual #(.NUM_RAILS(NUM_RAILS)) u_qual (
    .en_s    (sync_bus[SW-1]),
    .card_s  (sync_bus[SW-2]),
    .host_s  (sync_bus[SW-3]),
    .rails_s (rails_s),
    .qual    (qual)
  );

  slot_release_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .go       (qual.rel_ok),
    .released (released)
  );

  always_ff @(posedge clk) begin
    if (rst) refclk_q <= 1'b0;
    else     refclk_q <= qual.clk_ok;
  end

  assign refclk_en  = refclk_q;
  assign card_rst_n = released;

endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk #(
  parameter int NUM_RAILS          = 3,
  parameter int SYNC_STAGES        = 2,
  parameter int unsigned TICKS_PER_US = 250,
  parameter int unsigned DELAY_US  = 10000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 chip_en,
  input logic                 card_in,
  input logic                 host_rst_n,
  input logic [NUM_RAILS-1:0] rail_good,
  input logic                 card_rst_n,
  input logic                 refclk_en
);

  localparam int LAT = SYNC_STAGES + 1;
  localparam int unsigned DCYC = TICKS_PER_US * DELAY_US;

  logic [7:0]  warm;
  logic [31:0] run;
  logic        pwr_ok, all_ok, ready;

  assign pwr_ok = chip_en && card_in && (&rail_good);
  assign all_ok = pwr_ok && host_rst_n;
  assign ready  = (warm == 8'(LAT + 1));

  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (!ready) warm <= warm + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !all_ok) run <= '0;
    else if (run != 32'hFFFF_FFFF) run <= run + 1'b1;
  end

  assert_clk_tracks_R1: assert property (@(posedge clk) disable iff (rst || !ready)
    refclk_en == $past(pwr_ok, LAT));

  assert_host_ignored_R2: assert property (@(posedge clk) disable iff (rst || !ready)
    ($past(pwr_ok, LAT) && !$past(host_rst_n, LAT)) |-> refclk_en);

  assert_rst_needs_clk_R3: assert property (@(posedge clk) disable iff (rst)
    card_rst_n |-> refclk_en);

  assert_rst_needs_all_R5: assert property (@(posedge clk) disable iff (rst || !ready)
    card_rst_n |-> $past(all_ok, LAT));

  assert_min_delay_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(card_rst_n) |-> (run >= DCYC));

  assert_disable_forces_R7: assert property (@(posedge clk) disable iff (rst || !ready)
    !$past(chip_en, LAT) |-> (!card_rst_n && !refclk_en));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!card_rst_n && !refclk_en));

endmodule

bind card_slot_seq slot_seq_chk #(
  .NUM_RAILS(NUM_RAILS), .SYNC_STAGES(SYNC_STAGES),
  .TICKS_PER_US(TICKS_PER_US), .DELAY_US(DELAY_US)
) u_chk (
  .clk(clk), .rst(rst), .chip_en(chip_en), .card_in(card_in),
  .host_rst_n(host_rst_n), .rail_good(rail_good),
  .card_rst_n(card_rst_n), .refclk_en(refclk_en)
);

// File: tb/sim_card_slot_seq.sv
`timescale 1ns/1ps
module sim_card_slot_seq;

  localparam int NR  = 3;
  localparam int SS  = 2;
  localparam int TPU = 1;
  localparam int DUS = 4000;
  localparam int D   = TPU * DUS;
  localparam int LAT = SS + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0, card_in = 1'b0, host_rst_n = 1'b0;
  logic [NR-1:0] rail_good = '0;
  logic card_rst_n, refclk_en;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  card_slot_seq #(.NUM_RAILS(NR), .SYNC_STAGES(SS), .TICKS_PER_US(TPU),
                  .DELAY_US(DUS)) u0 (
    .clk(clk), .rst(rst), .chip_en(chip_en), .card_in(card_in),
    .host_rst_n(host_rst_n), .rail_good(rail_good),
    .card_rst_n(card_rst_n), .refclk_en(refclk_en));

  // {chip_en, card_in, host_rst_n, rail_good[2:0], exp_refclk, exp_rst_n}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'b000_000_00, 8'b111_111_10, 8'b110_111_10, 8'b011_111_00,
    8'b101_111_00, 8'b111_011_00, 8'b111_101_00, 8'b111_110_00,
    8'b110_110_00, 8'b111_111_10, 8'b100_111_00, 8'b110_111_10
  };

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {chip_en, card_in, host_rst_n, rail_good} = v;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    edges(5);
    check("R8 reset rst_n", card_rst_n, 1'b0);
    check("R8 reset refclk", refclk_en, 1'b0);
    rst = 1'b0;
    edges(2);

    // R1 R2 R3 R7: table of steady patterns, output checked LAT edges later
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][7:2]);
      edges(LAT);
      check("R1 table refclk", refclk_en, VEC[i][1]);
      check("R3 table rst_n", card_rst_n, VEC[i][0]);
    end

    // R4: full release delay from all-off
    drive(6'b000_000);
    edges(LAT + 2);
    drive(6'b111_111);
    edges(SS + D - 1);
    check("R4 early", card_rst_n, 1'b0);
    edges(1);
    check("R4 release", card_rst_n, 1'b1);
    check("R1 refclk on", refclk_en, 1'b1);

    // R5 and R2: host reset request
    host_rst_n = 1'b0;
    edges(LAT - 1);
    check("R5 before", card_rst_n, 1'b1);
    edges(1);
    check("R5 host drop", card_rst_n, 1'b0);
    check("R2 refclk kept", refclk_en, 1'b1);
    host_rst_n = 1'b1;
    edges(SS + D - 1);
    check("R4 re-early", card_rst_n, 1'b0);
    edges(1);
    check("R4 re-release", card_rst_n, 1'b1);

    // R5 rail loss, then R6 restart on a glitch mid-count
    rail_good[0] = 1'b0;
    edges(LAT);
    check("R5 rail drop", card_rst_n, 1'b0);
    check("R1 rail drop refclk", refclk_en, 1'b0);
    rail_good[0] = 1'b1;
    edges(D / 2);
    card_in = 1'b0;
    edges(2);
    card_in = 1'b1;
    edges(SS + D - 1);
    check("R6 restart early", card_rst_n, 1'b0);
    edges(1);
    check("R6 restart release", card_rst_n, 1'b1);

    // R7: chip enable low
    chip_en = 1'b0;
    edges(LAT);
    check("R7 rst_n off", card_rst_n, 1'b0);
    check("R7 refclk off", refclk_en, 1'b0);
    edges(20);
    check("R7 held", card_rst_n | refclk_en, 1'b0);
    chip_en = 1'b1;
    edges(SS + D);
    check("R4 after enable", card_rst_n, 1'b1);

    // R8: reset while released
    rst = 1'b1;
    edges(1);
    check("R8 mid rst_n", card_rst_n, 1'b0);
    check("R8 mid refclk", refclk_en, 1'b0);
    rst = 1'b0;
    edges(SS + D);
    check("R4 after reset", card_rst_n, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule